// File: doc/BRIEF.md
# Dual-Master Windowed Bus Arbiter

This block lets two bus masters share one external-bus peripheral port. One master is the primary and the other is the secondary. Each master presents a single-beat request: valid, address, write flag and write data. A request completes in the cycle where the master sees ready high. The arbiter routes one master at a time to the downstream port. A grant stays in place until the peripheral finishes the transfer. Read data and an error flag come back to the master in the completing cycle.

Two programmable features change the plain fixed-priority behaviour. First, the secondary master can open a timed window. During that window every primary request stalls and only the secondary can win the bus. The window runs for a programmed number of clocks and then fixed priority returns. Second, an ownership register assigns each of the four address regions to the primary, the secondary, or both. A request to a region the requester does not own is never forwarded. It completes at once with an error. Register writes arrive on a small configuration port that is tagged with the writing master. Each register accepts writes from only one of the two masters.

Top module: `dual_bus_arbiter`

## Requirements
- R1: After reset no request is forwarded, `p_ready`/`s_ready` are low, no window is open, and the ownership register reads all ones, so every region is owned by both masters.
- R2: Outside a window, with no transfer in progress and both masters making owned requests, the primary wins. `dn_valid` is high, `dn_addr` carries the primary address, and `s_ready` stays low.
- R3: Once a master is granted and `dn_ready` is low, the grant stays with that master on following cycles until a cycle with `dn_ready` high. The other master is not forwarded in the meantime.
- R4: A configuration write with `cfg_src`=1 and `cfg_sel`=1 opens a window of L cycles, where L is the window length register. The window covers the L cycles that follow the clock edge that takes the write. During it the secondary wins whenever both masters request. After it the primary wins again. L=0 opens no window.
- R5: A window never preempts a transfer already in progress. A primary grant held with `dn_ready` low stays with the primary after a window opens, until the transfer completes.
- R6: The region is `addr[AW-1:AW-2]`. For region r, bit 2r of the ownership register grants the primary and bit 2r+1 grants the secondary. The ownership register is written with `cfg_src`=0 and `cfg_sel`=2, taking `cfg_wdata[7:0]`.
- R7: A request to a region the requester does not own gets ready=1 and err=1 in the same cycle, and `dn_valid` stays low for it.
- R8: Writes to the window length (`cfg_sel`=0) or the window start (`cfg_sel`=1) with `cfg_src`=0 have no effect.
- R9: Writes to the ownership register with `cfg_src`=1 have no effect.
- R10: During a window the primary is not forwarded even when the secondary is idle. Its ready stays low until the window ends.
- R11: For a forwarded request, the master's read data equals `dn_rdata` and its err is low. Address, write flag and write data reach the downstream port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_valid | input | 1 | Primary request valid |
| p_ready | output | 1 | Primary request completes this cycle |
| p_addr | input | AW | Primary address |
| p_we | input | 1 | Primary write flag |
| p_wdata | input | DW | Primary write data |
| p_rdata | output | DW | Primary read data |
| p_err | output | 1 | Primary request blocked by ownership |
| s_valid | input | 1 | Secondary request valid |
| s_ready | output | 1 | Secondary request completes this cycle |
| s_addr | input | AW | Secondary address |
| s_we | input | 1 | Secondary write flag |
| s_wdata | input | DW | Secondary write data |
| s_rdata | output | DW | Secondary read data |
| s_err | output | 1 | Secondary request blocked by ownership |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | 1 | Writer: 0 primary, 1 secondary |
| cfg_sel | input | 2 | 0 window length, 1 window start, 2 ownership |
| cfg_wdata | input | DW | Configuration write data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream transfer completes |
| dn_addr | output | AW | Downstream address |
| dn_we | output | 1 | Downstream write flag |
| dn_wdata | output | DW | Downstream write data |
| dn_rdata | input | DW | Downstream read data |

## Verification
The ownership filter is swept over all 256 ownership values, each of the four regions and both masters. This separates the region decode, the bit ordering inside each pair and the blocked-with-error path. The window is opened with lengths 0 to 6 while both masters request continuously. Counting the secondary wins gives the exact window length and its start edge. Separate patterns cover a stalled primary with an idle secondary, a held transfer with the peripheral not ready and a window opened during a held transfer. Register writes from the wrong master are also tried, and each of these patterns checks whether a grant can be stolen or a foreign write can leak through.

// File: rtl/dba_pkg.sv
package dba_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_PRI  = 2'd1,
        OWN_SEC  = 2'd2
    } owner_e;

    localparam logic [1:0] SEL_WLEN = 2'd0;
    localparam logic [1:0] SEL_WGO  = 2'd1;
    localparam logic [1:0] SEL_PROT = 2'd2;

    localparam int N_REGIONS = 4;
    localparam int PROT_W    = 2 * N_REGIONS;
endpackage

// File: rtl/dba_cfg_regs.sv
module dba_cfg_regs #(
    parameter int CNT_W = 8,
    parameter int DW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic                       cfg_src,
    input  logic [1:0]                 cfg_sel,
    input  logic [DW-1:0]              cfg_wdata,
    output logic [CNT_W-1:0]           win_len,
    output logic                       win_go,
    output logic [dba_pkg::PROT_W-1:0] prot
);
    import dba_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0]  win_len;
        logic [PROT_W-1:0] prot;
    } regs_t;

    regs_t regs_q, regs_d;

    always_comb begin
        regs_d = regs_q;
        win_go = 1'b0;
        if (cfg_wr && cfg_src) begin
            if (cfg_sel == SEL_WLEN) regs_d.win_len = cfg_wdata[CNT_W-1:0];
            if (cfg_sel == SEL_WGO)  win_go = 1'b1;
        end
        if (cfg_wr && !cfg_src && cfg_sel == SEL_PROT)
            regs_d.prot = cfg_wdata[PROT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.win_len <= '0;
            regs_q.prot    <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign win_len = regs_q.win_len;
    assign prot    = regs_q.prot;

    // R9
    prot_foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_src && cfg_sel == SEL_PROT) |=> $stable(regs_q.prot));

    // R8
    wlen_foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_src && cfg_sel == SEL_WLEN) |=> $stable(regs_q.win_len));
endmodule

// File: rtl/dba_window_timer.sv
module dba_window_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             active
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (load)
            tmr_d.cnt = len;
        else if (tmr_q.cnt != '0)
            tmr_d.cnt = tmr_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign active = (tmr_q.cnt != '0);

    // R4
    win_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));
endmodule

// File: rtl/dba_own_filter.sv
module dba_own_filter #(
    parameter int AW         = 16,
    parameter int MASTER_IDX = 0
) (
    input  logic                       valid,
    input  logic [AW-1:0]              addr,
    input  logic [dba_pkg::PROT_W-1:0] prot,
    output logic                       fwd,
    output logic                       blocked
);
    logic [1:0] region;
    logic       owned;

    always_comb begin
        region  = addr[AW-1 -: 2];
        owned   = prot[2 * int'(region) + MASTER_IDX];
        fwd     = valid && owned;
        blocked = valid && !owned;
    end
endmodule

// File: rtl/dba_grant_ctrl.sv
module dba_grant_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic p_req,
    input  logic s_req,
    input  logic win_active,
    input  logic dn_ready,
    output logic p_gnt,
    output logic s_gnt
);
    import dba_pkg::*;

    typedef struct packed {
        owner_e owner;
    } arb_t;

    arb_t   arb_q, arb_d;
    owner_e cur;

    always_comb begin
        arb_d = arb_q;
        if (arb_q.owner != OWN_NONE) cur = arb_q.owner;
        else if (win_active)         cur = s_req ? OWN_SEC : OWN_NONE;
        else if (p_req)              cur = OWN_PRI;
        else if (s_req)              cur = OWN_SEC;
        else                         cur = OWN_NONE;
        p_gnt = (cur == OWN_PRI) && p_req;
        s_gnt = (cur == OWN_SEC) && s_req;
        arb_d.owner = ((p_gnt || s_gnt) && !dn_ready) ? cur : OWN_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q.owner <= OWN_NONE;
        else        arb_q <= arb_d;
    end

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({p_gnt, s_gnt}));

    // R3
    hold_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_gnt && !dn_ready) |=> !s_gnt);

    // R3
    hold_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_gnt && !dn_ready) |=> !p_gnt);

    // R10
    win_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_active && arb_q.owner != OWN_PRI) |-> !p_gnt);
endmodule

// File: rtl/dual_bus_arbiter.sv
module dual_bus_arbiter #(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int CNT_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p_valid,
    output logic          p_ready,
    input  logic [AW-1:0] p_addr,
    input  logic          p_we,
    input  logic [DW-1:0] p_wdata,
    output logic [DW-1:0] p_rdata,
    output logic          p_err,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [AW-1:0] s_addr,
    input  logic          s_we,
    input  logic [DW-1:0] s_wdata,
    output logic [DW-1:0] s_rdata,
    output logic          s_err,
    input  logic          cfg_wr,
    input  logic          cfg_src,
    input  logic [1:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [AW-1:0] dn_addr,
    output logic          dn_we,
    output logic [DW-1:0] dn_wdata,
    input  logic [DW-1:0] dn_rdata
);
    import dba_pkg::*;

    logic [CNT_W-1:0]  win_len;
    logic              win_go;
    logic              win_active;
    logic [PROT_W-1:0] prot;
    logic              p_fwd, p_blk, s_fwd, s_blk;
    logic              p_gnt, s_gnt;

    dba_cfg_regs #(.CNT_W(CNT_W), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_src(cfg_src),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .win_len(win_len), .win_go(win_go), .prot(prot)
    );

    dba_window_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(win_go), .len(win_len),
        .active(win_active)
    );

    dba_own_filter #(.AW(AW), .MASTER_IDX(0)) u_pflt (
        .valid(p_valid), .addr(p_addr), .prot(prot),
        .fwd(p_fwd), .blocked(p_blk)
    );

    dba_own_filter #(.AW(AW), .MASTER_IDX(1)) u_sflt (
        .valid(s_valid), .addr(s_addr), .prot(prot),
        .fwd(s_fwd), .blocked(s_blk)
    );

    dba_grant_ctrl u_gnt (
        .clk(clk), .rst_n(rst_n), .p_req(p_fwd), .s_req(s_fwd),
        .win_active(win_active), .dn_ready(dn_ready),
        .p_gnt(p_gnt), .s_gnt(s_gnt)
    );

    always_comb begin
        dn_valid = p_gnt || s_gnt;
        dn_addr  = s_gnt ? s_addr  : p_addr;
        dn_we    = s_gnt ? s_we    : p_we;
        dn_wdata = s_gnt ? s_wdata : p_wdata;
        p_ready  = p_blk || (p_gnt && dn_ready);
        s_ready  = s_blk || (s_gnt && dn_ready);
        p_err    = p_blk;
        s_err    = s_blk;
        p_rdata  = dn_rdata;
        s_rdata  = dn_rdata;
    end

    // R7
    p_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_err |-> !p_gnt);

    // R7
    s_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_err |-> !s_gnt);

    // R10
    win_no_pri_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_active && !$past(p_gnt && !dn_ready)) |-> !(p_ready && !p_err));
endmodule

// File: tb/dual_bus_arbiter_bench.sv
`timescale 1ns/1ps
module dual_bus_arbiter_bench;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          p_valid, p_we, s_valid, s_we;
    logic [AW-1:0] p_addr, s_addr;
    logic [DW-1:0] p_wdata, s_wdata;
    logic          p_ready, p_err, s_ready, s_err;
    logic [DW-1:0] p_rdata, s_rdata;
    logic          cfg_wr, cfg_src;
    logic [1:0]    cfg_sel;
    logic [DW-1:0] cfg_wdata;
    logic          dn_valid, dn_ready, dn_we;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_wdata, dn_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_bus_arbiter #(.AW(AW), .DW(DW), .CNT_W(8)) u_dual_bus_arbiter (
        .clk(clk), .rst_n(rst_n),
        .p_valid(p_valid), .p_ready(p_ready), .p_addr(p_addr), .p_we(p_we),
        .p_wdata(p_wdata), .p_rdata(p_rdata), .p_err(p_err),
        .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_we(s_we),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .s_err(s_err),
        .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_we(dn_we),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start just after a falling edge and return at one.
    task automatic cfg_write(input logic src, input logic [1:0] sel, input logic [DW-1:0] val);
        cfg_wr = 1'b1; cfg_src = src; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic idle_all();
        p_valid = 1'b0; s_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_src = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        p_valid = 0; p_we = 0; p_addr = '0; p_wdata = '0;
        s_valid = 0; s_we = 0; s_addr = '0; s_wdata = '0;
        dn_ready = 1'b1; dn_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk(!dn_valid && !p_ready && !s_ready, "R1 idle", {dn_valid, p_ready, s_ready}, 0);
        @(negedge clk);
        // R1: all regions owned by both after reset
        for (int r = 0; r < 4; r++) begin
            s_valid = 1'b1; s_addr = {r[1:0], 14'h0011};
            #1;
            chk(dn_valid && !s_err && dn_addr == s_addr, "R1 sec owns", {s_err, dn_addr}, {1'b0, s_addr});
            s_valid = 1'b0; p_valid = 1'b1; p_addr = {r[1:0], 14'h0022};
            #1;
            chk(dn_valid && !p_err && dn_addr == p_addr, "R1 pri owns", {p_err, dn_addr}, {1'b0, p_addr});
            @(negedge clk);
            p_valid = 1'b0;
        end

        // R2: fixed priority in every region, R11 pass-through
        for (int r = 0; r < 4; r++) begin
            p_valid = 1; p_addr = {r[1:0], 14'h0100}; p_we = 1; p_wdata = 16'hA5A0 + DW'(r);
            s_valid = 1; s_addr = {r[1:0], 14'h0200}; s_we = 0;
            dn_rdata = 16'h1000 + DW'(r);
            #1;
            chk(dn_addr == p_addr && p_ready && !s_ready, "R2 pri wins", dn_addr, p_addr);
            chk(dn_we == 1'b1 && dn_wdata == p_wdata && p_rdata == dn_rdata && !p_err,
                "R11 pass", dn_wdata, p_wdata);
            @(negedge clk);
        end
        idle_all();
        @(negedge clk);

        // R3: grant held while peripheral not ready
        dn_ready = 1'b0;
        s_valid = 1; s_addr = 16'h0300;
        #1;
        chk(dn_valid && dn_addr == 16'h0300 && !s_ready, "R3 sec granted", dn_addr, 16'h0300);
        @(negedge clk);
        p_valid = 1; p_addr = 16'h0400;
        #1;
        chk(dn_addr == 16'h0300 && !p_ready, "R3 held", dn_addr, 16'h0300);
        @(negedge clk);
        #1;
        chk(dn_addr == 16'h0300 && !p_ready, "R3 held 2", dn_addr, 16'h0300);
        dn_ready = 1'b1;
        #1;
        chk(s_ready && !p_ready, "R3 completes", s_ready, 1);
        @(negedge clk);
        s_valid = 0;
        #1;
        chk(dn_addr == 16'h0400 && p_ready, "R3 released", dn_addr, 16'h0400);
        @(negedge clk);
        idle_all();

        // R5: window opened during a held primary transfer
        cfg_write(1'b1, 2'd0, 16'd4);
        dn_ready = 1'b0;
        p_valid = 1; p_addr = 16'h0500;
        @(negedge clk);
        s_valid = 1; s_addr = 16'h0600;
        cfg_write(1'b1, 2'd1, 16'd0);
        #1;
        chk(dn_addr == 16'h0500 && !s_ready, "R5 no preempt", dn_addr, 16'h0500);
        dn_ready = 1'b1;
        #1;
        chk(p_ready, "R5 pri completes", p_ready, 1);
        @(negedge clk);
        #1;
        chk(dn_addr == 16'h0600 && s_ready && !p_ready, "R5 window after", dn_addr, 16'h0600);
        idle_all();
        repeat (6) @(negedge clk);

        // R4: window length sweep with both masters requesting
        for (int len = 0; len <= 6; len++) begin
            int sec_wins;
            sec_wins = 0;
            cfg_write(1'b1, 2'd0, DW'(len));
            cfg_write(1'b1, 2'd1, 16'd0);
            p_valid = 1; p_addr = 16'h0700; s_valid = 1; s_addr = 16'h0800;
            for (int i = 0; i < len + 2; i++) begin
                #1;
                if (i < len)
                    chk(dn_addr == 16'h0800 && s_ready, "R4 window sec", dn_addr, 16'h0800);
                else
                    chk(dn_addr == 16'h0700 && p_ready, "R4 after window", dn_addr, 16'h0700);
                if (s_ready) sec_wins++;
                @(negedge clk);
            end
            chk(sec_wins == len, "R4 window length", sec_wins, len);
            idle_all();
            @(negedge clk);
        end

        // R10: primary stalled in a window with the secondary idle
        cfg_write(1'b1, 2'd0, 16'd3);
        cfg_write(1'b1, 2'd1, 16'd0);
        p_valid = 1; p_addr = 16'h0900;
        for (int i = 0; i < 5; i++) begin
            #1;
            chk(p_ready == (i >= 3) && dn_valid == (i >= 3), "R10 stall", {p_ready, dn_valid},
                {2{i >= 3}});
            @(negedge clk);
        end
        idle_all();

        // R8: primary writes to window registers ignored
        cfg_write(1'b0, 2'd0, 16'd0);
        cfg_write(1'b0, 2'd1, 16'd0);
        p_valid = 1; p_addr = 16'h0A00; s_valid = 1; s_addr = 16'h0B00;
        #1;
        chk(dn_addr == 16'h0A00, "R8 start ignored", dn_addr, 16'h0A00);
        @(negedge clk);
        idle_all();
        cfg_write(1'b1, 2'd1, 16'd0);
        p_valid = 1; s_valid = 1;
        begin
            int sec_wins;
            sec_wins = 0;
            for (int i = 0; i < 5; i++) begin
                #1;
                if (s_ready) sec_wins++;
                @(negedge clk);
            end
            chk(sec_wins == 3, "R8 length kept", sec_wins, 3);
        end
        idle_all();
        @(negedge clk);

        // R9: secondary write to ownership ignored
        cfg_write(1'b1, 2'd2, 16'h0000);
        p_valid = 1; p_addr = 16'h0C00;
        #1;
        chk(dn_valid && !p_err, "R9 prot ignored", p_err, 0);
        @(negedge clk);
        idle_all();

        // R6/R7: ownership sweep
        for (int pv = 0; pv < 256; pv++) begin
            cfg_write(1'b0, 2'd2, DW'(pv));
            for (int r = 0; r < 4; r++) begin
                for (int m = 0; m < 2; m++) begin
                    bit own;
                    logic [AW-1:0] a;
                    own = pv[2 * r + m];
                    a = {r[1:0], 6'h0, pv[7:0]};
                    if (m == 0) begin p_valid = 1; p_addr = a; end
                    else        begin s_valid = 1; s_addr = a; end
                    #1;
                    if (m == 0)
                        chk(p_ready && p_err == !own && dn_valid == own &&
                            (!own || dn_addr == a), own ? "R6 pri owned" : "R7 pri blocked",
                            {p_ready, p_err, dn_valid}, {1'b1, !own, own});
                    else
                        chk(s_ready && s_err == !own && dn_valid == own &&
                            (!own || dn_addr == a), own ? "R6 sec owned" : "R7 sec blocked",
                            {s_ready, s_err, dn_valid}, {1'b1, !own, own});
                    @(negedge clk);
                    idle_all();
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule